// File: doc/BRIEF.md
# Low-Power SDRAM Command Decoder and Power-State Tracker

This block watches the control pins of a low-power SDRAM at every rising clock edge and turns each edge into one decoded command. The command depends on the clock-enable level at this edge and at the previous edge, on the chip-select and the three strobes, on A10 and on the bank address. From the stream of decoded commands it keeps the device's power state and a per-bank open/closed record. It pulses an error flag for command sequences the device does not accept. These include bank misuse, activate-to-access and precharge-to-activate spacing that is too short, mode writes or refresh with rows open, and anything other than no-operation while the device is leaving self refresh.

A second, small datapath produces the data-mask views. Write data is masked in the same cycle as the mask pin. The read output enable follows the mask pin two edges later, and it is frozen while the clock is suspended. The decoder is meant to sit beside a controller or a memory model as a protocol monitor. The error pulse and the power-state code give a scoreboard everything it needs.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset, cmdCode is 0, pwrState is 0 (idle), errPulse is 0, rdHiZ is 1, all banks are closed and the previous clock-enable is taken as high.
- R2: With clock-enable high at both edges and csN low, the strobe pattern {rasN,casN,weN} decodes to cmdCode, visible after that edge: 000 mode write (1 when ba=0, 2 when ba=1), 011 activate (3), 101 read (4, or 5 when a10=1), 100 write (6, or 7 when a10=1), 010 precharge (8 for one bank, or 9 when a10=1 for all banks), 110 burst stop (10), 001 auto refresh (11).
- R3: csN high, or csN low with pattern 111, decodes as no-operation (code 0) and changes neither bank state nor pwrState.
- R4: Activate opens the addressed bank. pwrState is 1 (active) while any bank is open and 0 (idle) otherwise. Precharge closes the addressed bank, precharge-all closes every bank, and read or write with a10=1 closes its bank.
- R5: errPulse is high for the cycle after an edge that activates an open bank, or that reads or writes a closed bank. The offending command changes no state.
- R6: A read or write fewer than TRCD edges after its bank's activate is an error. An activate fewer than TRP edges after that bank was closed is an error.
- R7: Clock-enable falling with a no-operation or deselect gives code 13. The state becomes 3 (power-down) if all banks are idle, or 4 (clock suspend) if a bank is open. Clock-enable held low gives code 0. Clock-enable rising gives code 15 and returns to idle or active.
- R8: Clock-enable falling with the refresh pattern gives code 12 and state 2 (self refresh). Rising gives code 15 and state 6 for TXSR edges, after which the state is 0.
- R9: During the TXSR window any command other than no-operation raises errPulse and is ignored. If the window ends with fewer than two no-operation edges, errPulse is raised on its last edge.
- R10: Clock-enable falling with the burst-stop pattern gives code 14 and state 5 (deep power-down), and closes all banks. Rising returns to state 0. Burst stop with clock-enable high has no effect.
- R11: wrMask equals dqm in the same cycle. rdHiZ after edge n+1 equals dqm sampled at edge n. In states 2, 3, 5 and 6 both outputs are forced to 1. In state 4 rdHiZ holds its value.
- R12: A mode write, an extended mode write or a refresh (auto or self) with any bank open is an error. A mode write with ba of 2 or 3 is an error and decodes as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable pin |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| a10 | input | 1 | Auto-precharge / all-banks select |
| ba | input | $clog2(NBANK) | Bank address |
| dqm | input | 1 | Data mask pin |
| cmdCode | output | 4 | Decoded command of the last edge |
| pwrState | output | 3 | Current power state |
| errPulse | output | 1 | Illegal command at the last edge |
| wrMask | output | 1 | Write data mask, zero latency |
| rdHiZ | output | 1 | Read output disable, two-edge latency |

## Verification
A wrong open-bank bit does not show at once. It appears on the next access to that bank as an errPulse that should not be there, or as a missing one, and on pwrState as active where idle is expected. The bench therefore follows every bank operation with an access that exposes the bit. A stuck window counter or wrong mode register shows on pwrState within one edge of the exit, or at the end of the TXSR window. A slip in the mask pipeline shows on rdHiZ one edge early or late during a bit-pattern sweep.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;
  typedef enum logic [3:0] {
    C_NOP = 4'd0, C_MRS, C_EMRS, C_ACT, C_RD, C_RDA, C_WR, C_WRA,
    C_PRE, C_PREA, C_BST, C_REF, C_SREF_IN, C_PDN_IN, C_DPD_IN, C_EXIT
  } cmd_e;

  typedef enum logic [2:0] {
    P_IDLE = 3'd0, P_ACTIVE, P_SREF, P_PDN, P_CSUSP, P_DPD, P_XSR
  } pwr_e;

  typedef struct packed {
    logic freeze;
    logic dataOff;
  } dq_strobe_t;
endpackage

// File: rtl/sdcmd_ctrl.sv
`timescale 1ns/1ps
module sdcmd_ctrl import sdcmd_pkg::*; #(
  parameter int NBANK = 4,
  parameter int TRCD  = 3,
  parameter int TRP   = 3,
  parameter int TXSR  = 4,
  localparam int BAW  = $clog2(NBANK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cke,
  input  logic           csN,
  input  logic           rasN,
  input  logic           casN,
  input  logic           weN,
  input  logic           a10,
  input  logic [BAW-1:0] ba,
  output logic [3:0]     cmdCode,
  output logic [2:0]     pwrState,
  output logic           errPulse,
  output dq_strobe_t     strobe
);
  localparam int TMAX = (TRCD > TRP) ? TRCD : TRP;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int XW   = $clog2(TXSR + 1);

  logic             ckePrev;
  pwr_e             mode;
  cmd_e             dec;
  logic             decErr;
  logic [2:0]       pat;
  logic [NBANK-1:0] openMask, bankErr;
  logic             anyOpen, normEdge, isRw, wipe;
  logic             modeErr, xsrErr, xsrLast;
  logic [XW-1:0]    xsrCnt, nopCnt, nopsNow;

  assign pat = {rasN, casN, weN};

  // edge decode from the clock-enable pair and the pin pattern
  always_comb begin
    dec    = C_NOP;
    decErr = 1'b0;
    if (!ckePrev) begin
      dec = cke ? C_EXIT : C_NOP;
    end else if (!cke) begin
      if (!csN && pat == 3'b001)      dec = C_SREF_IN;
      else if (!csN && pat == 3'b110) dec = C_DPD_IN;
      else begin
        dec    = C_PDN_IN;
        decErr = !csN && pat != 3'b111;
      end
    end else if (!csN) begin
      case (pat)
        3'b000: begin
          if (ba == BAW'(0))      dec = C_MRS;
          else if (ba == BAW'(1)) dec = C_EMRS;
          else                    decErr = 1'b1;
        end
        3'b001:  dec = C_REF;
        3'b010:  dec = a10 ? C_PREA : C_PRE;
        3'b011:  dec = C_ACT;
        3'b100:  dec = a10 ? C_WRA : C_WR;
        3'b101:  dec = a10 ? C_RDA : C_RD;
        3'b110:  dec = C_BST;
        default: dec = C_NOP;
      endcase
    end
  end

  assign anyOpen  = |openMask;
  assign normEdge = (mode == P_IDLE) && ckePrev && cke;
  assign isRw     = dec inside {C_RD, C_RDA, C_WR, C_WRA};
  assign wipe     = (mode == P_IDLE) && ckePrev && !cke && dec == C_DPD_IN;

  // per-bank open bit and spacing timer
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic          selB, isOpen, doAct, doClose;
    logic [TW-1:0] tmr;
    assign selB    = (ba == BAW'(b));
    assign doAct   = normEdge && dec == C_ACT && selB && !isOpen && tmr == '0;
    assign doClose = normEdge && isOpen &&
                     ((selB && (dec == C_PRE ||
                                ((dec == C_RDA || dec == C_WRA) && tmr == '0))) ||
                      dec == C_PREA);
    assign bankErr[b] = normEdge && selB &&
                        ((dec == C_ACT && (isOpen || tmr != '0)) ||
                         (isRw && (!isOpen || tmr != '0)));
    assign openMask[b] = isOpen;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        isOpen <= 1'b0;
        tmr    <= '0;
      end else if (doAct) begin
        isOpen <= 1'b1;
        tmr    <= TW'(TRCD - 1);
      end else if (doClose) begin
        isOpen <= 1'b0;
        tmr    <= TW'(TRP - 1);
      end else if (wipe) begin
        isOpen <= 1'b0;
        tmr    <= '0;
      end else if (tmr != '0) begin
        tmr <= tmr - TW'(1);
      end
    end
  end

  assign modeErr = (mode == P_IDLE) && ckePrev &&
                   (decErr || (anyOpen && dec inside {C_MRS, C_EMRS, C_REF, C_SREF_IN}));
  assign xsrLast = (mode == P_XSR) && xsrCnt == XW'(TXSR - 1);
  assign nopsNow = nopCnt + XW'(dec == C_NOP);
  assign xsrErr  = (mode == P_XSR) &&
                   (dec != C_NOP || (xsrLast && nopsNow < XW'(2)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ckePrev  <= 1'b1;
      mode     <= P_IDLE;
      cmdCode  <= '0;
      errPulse <= 1'b0;
      xsrCnt   <= '0;
      nopCnt   <= '0;
    end else begin
      ckePrev  <= cke;
      cmdCode  <= dec;
      errPulse <= (|bankErr) | modeErr | xsrErr;
      case (mode)
        P_IDLE: if (ckePrev && !cke)
          mode <= (dec == C_SREF_IN) ? P_SREF :
                  (dec == C_DPD_IN)  ? P_DPD  :
                  anyOpen            ? P_CSUSP : P_PDN;
        P_SREF: if (dec == C_EXIT) begin
          mode   <= P_XSR;
          xsrCnt <= '0;
          nopCnt <= '0;
        end
        P_XSR: begin
          xsrCnt <= xsrCnt + XW'(1);
          nopCnt <= nopsNow;
          if (xsrLast) mode <= P_IDLE;
        end
        default: if (dec == C_EXIT) mode <= P_IDLE;
      endcase
    end
  end

  assign pwrState       = (mode == P_IDLE && anyOpen) ? P_ACTIVE : mode;
  assign strobe.freeze  = (mode == P_CSUSP);
  assign strobe.dataOff = mode inside {P_SREF, P_PDN, P_DPD, P_XSR};

  a_r7_pdn_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    pwrState == P_PDN |-> openMask == '0);
  a_r8_sref_leaves_to_xsr: assert property (@(posedge clk) disable iff (!rst_n)
    pwrState == P_SREF |=> pwrState inside {P_SREF, P_XSR});
  a_r9_xsr_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pwrState == P_XSR |=> pwrState inside {P_XSR, P_IDLE});
  a_r10_dpd_exit_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrState == P_DPD && cke) |=> pwrState == P_IDLE);
endmodule

// File: rtl/sdcmd_dqm.sv
`timescale 1ns/1ps
module sdcmd_dqm import sdcmd_pkg::*; #(
  parameter int RDLAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dqm,
  input  dq_strobe_t strobe,
  output logic       wrMask,
  output logic       rdHiZ
);
  logic [RDLAT-1:0] pipe;

  if (RDLAT == 1) begin : g_lat1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pipe <= '1;
      else if (!strobe.freeze) pipe <= dqm;
    end
  end else begin : g_latn
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pipe <= '1;
      else if (!strobe.freeze) pipe <= {pipe[RDLAT-2:0], dqm};
    end
  end

  assign wrMask = dqm | strobe.dataOff;
  assign rdHiZ  = pipe[RDLAT-1] | strobe.dataOff;

  if (RDLAT == 2) begin : g_chk
    a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n, 2) && !$past(strobe.freeze) && !$past(strobe.freeze, 2) && !strobe.dataOff)
        |-> rdHiZ == $past(dqm, 2));
  end
endmodule

// File: rtl/sdram_cmd_tracker.sv
`timescale 1ns/1ps
module sdram_cmd_tracker import sdcmd_pkg::*; #(
  parameter int NBANK = 4,
  parameter int TRCD  = 3,
  parameter int TRP   = 3,
  parameter int TXSR  = 4,
  parameter int RDLAT = 2,
  localparam int BAW  = $clog2(NBANK)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cke,
  input  logic           csN,
  input  logic           rasN,
  input  logic           casN,
  input  logic           weN,
  input  logic           a10,
  input  logic [BAW-1:0] ba,
  input  logic           dqm,
  output logic [3:0]     cmdCode,
  output logic [2:0]     pwrState,
  output logic           errPulse,
  output logic           wrMask,
  output logic           rdHiZ
);
  dq_strobe_t strobe;

  sdcmd_ctrl #(.NBANK(NBANK), .TRCD(TRCD), .TRP(TRP), .TXSR(TXSR)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .a10(a10), .ba(ba), .cmdCode(cmdCode), .pwrState(pwrState),
    .errPulse(errPulse), .strobe(strobe)
  );

  sdcmd_dqm #(.RDLAT(RDLAT)) u_dqm (
    .clk(clk), .rst_n(rst_n), .dqm(dqm), .strobe(strobe),
    .wrMask(wrMask), .rdHiZ(rdHiZ)
  );
endmodule

// File: tb/sdram_cmd_tracker_test.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, a10 = 1'b0, dqm = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [3:0] cmdCode;
  logic [2:0] pwrState;
  logic errPulse, wrMask, rdHiZ;
  int tests = 0, fails = 0;
  bit done = 0;

  localparam logic [3:0] K_NOP = 4'b0111, K_MRS = 4'b0000, K_REF = 4'b0001,
                         K_PRE = 4'b0010, K_ACT = 4'b0011, K_WR = 4'b0100,
                         K_RD = 4'b0101, K_BST = 4'b0110;

  always #2 clk = ~clk;

  sdram_cmd_tracker uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .a10(a10), .ba(ba), .dqm(dqm), .cmdCode(cmdCode),
    .pwrState(pwrState), .errPulse(errPulse), .wrMask(wrMask), .rdHiZ(rdHiZ)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drv(input logic ck, input logic [3:0] p, input logic a, input logic [1:0] b);
    cke = ck; {csN, rasN, casN, weN} = p; a10 = a; ba = b;
    @(posedge clk); #1;
  endtask

  task automatic st(input string req, input int code, input int pwr, input int err);
    chk({req, " code"}, cmdCode, code);
    chk({req, " state"}, pwrState, pwr);
    chk({req, " err"}, errPulse, err);
  endtask

  function automatic int expCode(input logic [3:0] p, input logic a, input logic [1:0] b);
    if (p[3]) return 0;
    case (p[2:0])
      3'd0:    return (b == 0) ? 1 : ((b == 1) ? 2 : 0);
      3'd1:    return 11;
      3'd2:    return a ? 9 : 8;
      3'd3:    return 3;
      3'd4:    return a ? 7 : 6;
      3'd5:    return a ? 5 : 4;
      3'd6:    return 10;
      default: return 0;
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] bits;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chk("R1 code", cmdCode, 0); chk("R1 state", pwrState, 0);
    chk("R1 err", errPulse, 0); chk("R1 rdHiZ", rdHiZ, 1); chk("R1 wrMask", wrMask, 0);

    // R2 / R3 decode sweep, clock-enable high
    for (int p = 0; p < 16; p++)
      for (int a = 0; a < 2; a++) begin
        drv(1'b1, 4'(p), 1'(a), 2'd0);
        chk(p[3] ? "R3 deselect" : "R2 decode", cmdCode, expCode(4'(p), 1'(a), 2'd0));
      end
    drv(1, K_PRE, 1, 0); drv(1, K_NOP, 0, 0); drv(1, K_NOP, 0, 0); drv(1, K_NOP, 0, 0);
    st("R3 nop idle", 0, 0, 0);

    // R4 / R5 / R6 bank tracking and spacing
    drv(1, K_ACT, 0, 1); st("R4 act", 3, 1, 0);
    drv(1, K_RD, 0, 1);  st("R6 early read", 4, 1, 1);
    drv(1, K_NOP, 0, 0); chk("R6 err clears", errPulse, 0);
    drv(1, K_RD, 0, 1);  st("R6 read at trcd", 4, 1, 0);
    drv(1, K_ACT, 0, 1); chk("R5 act open bank", errPulse, 1);
    drv(1, K_ACT, 0, 2); st("R4 act second", 3, 1, 0);
    drv(1, K_PRE, 0, 1); st("R4 pre one", 8, 1, 0);
    drv(1, K_ACT, 0, 1); chk("R6 early act", errPulse, 1);
    drv(1, K_NOP, 0, 0); drv(1, K_NOP, 0, 0);
    drv(1, K_ACT, 0, 1); st("R6 act at trp", 3, 1, 0);
    drv(1, K_PRE, 1, 0); st("R4 pre all", 9, 0, 0);
    drv(1, K_WR, 0, 3);  st("R5 write closed", 6, 0, 1);
    drv(1, K_NOP, 0, 0);
    drv(1, K_ACT, 0, 0); st("R4 act b0", 3, 1, 0);
    drv(1, K_NOP, 0, 0); drv(1, K_NOP, 0, 0);
    drv(1, K_RD, 1, 0);  st("R4 read autopre", 5, 0, 0);
    drv(1, K_RD, 0, 0);  chk("R4 bank closed after autopre", errPulse, 1);
    drv(1, K_NOP, 0, 0);
    drv(1, K_ACT, 0, 0); st("R4 reopen", 3, 1, 0);

    // R12 mode writes and refresh
    drv(1, K_MRS, 0, 0); st("R12 mrs open", 1, 1, 1);
    drv(1, K_REF, 0, 0); st("R12 ref open", 11, 1, 1);
    drv(1, K_PRE, 1, 0); drv(1, K_NOP, 0, 0); drv(1, K_NOP, 0, 0);
    drv(1, K_MRS, 0, 2); st("R12 mrs bad bank", 0, 0, 1);
    drv(1, K_MRS, 0, 1); st("R12 emrs", 2, 0, 0);
    drv(1, K_REF, 0, 0); st("R12 ref idle", 11, 0, 0);
    drv(1, K_BST, 0, 0); st("R10 burst stop", 10, 0, 0);

    // R7 power-down and R11 forced masks
    drv(0, K_NOP, 0, 0); st("R7 pdn entry", 13, 3, 0);
    chk("R11 wrMask forced", wrMask, 1); chk("R11 rdHiZ forced", rdHiZ, 1);
    drv(0, K_NOP, 0, 0); st("R7 pdn hold", 0, 3, 0);
    drv(1, K_NOP, 0, 0); st("R7 pdn exit", 15, 0, 0);

    // R7 clock suspend with R11 freeze
    dqm = 1'b1;
    drv(1, K_ACT, 0, 0); drv(1, K_NOP, 0, 0);
    drv(0, K_NOP, 0, 0); st("R7 suspend entry", 13, 4, 0);
    dqm = 1'b0;
    for (int i = 0; i < 2; i++) begin
      drv(0, K_NOP, 0, 0);
      chk("R7 suspend state", pwrState, 4);
      chk("R11 rdHiZ frozen", rdHiZ, 1); chk("R11 wrMask in suspend", wrMask, 0);
    end
    drv(1, K_NOP, 0, 0); st("R7 suspend exit", 15, 1, 0); chk("R11 rdHiZ exit", rdHiZ, 1);
    drv(1, K_NOP, 0, 0); chk("R11 rdHiZ resume 1", rdHiZ, 1);
    drv(1, K_NOP, 0, 0); chk("R11 rdHiZ resume 2", rdHiZ, 0);
    drv(1, K_PRE, 1, 0); drv(1, K_NOP, 0, 0); drv(1, K_NOP, 0, 0);

    // R11 read-mask latency sweep
    bits = 8'b1011_0010;
    for (int k = 0; k < 8; k++) begin
      dqm = bits[k];
      drv(1, K_NOP, 0, 0);
      chk("R11 wrMask", wrMask, bits[k]);
      if (k > 0) chk("R11 rdHiZ latency", rdHiZ, bits[k-1]);
    end
    dqm = 1'b0; drv(1, K_NOP, 0, 0); drv(1, K_NOP, 0, 0);

    // R8 self refresh
    drv(0, K_REF, 0, 0); st("R8 sref entry", 12, 2, 0); chk("R11 rdHiZ sref", rdHiZ, 1);
    drv(0, K_NOP, 0, 0); st("R8 sref hold", 0, 2, 0);
    drv(1, K_NOP, 0, 0); st("R8 sref exit", 15, 6, 0);
    for (int i = 0; i < 3; i++) begin
      drv(1, K_NOP, 0, 0); st("R8 window", 0, 6, 0);
    end
    drv(1, K_NOP, 0, 0); st("R8 window done", 0, 0, 0);

    // R9 illegal command inside the window
    drv(0, K_REF, 0, 0); drv(1, K_NOP, 0, 0);
    drv(1, K_ACT, 0, 0); st("R9 act in window", 3, 6, 1);
    drv(1, K_NOP, 0, 0); drv(1, K_NOP, 0, 0);
    drv(1, K_NOP, 0, 0); st("R9 window end ok", 0, 0, 0);
    drv(1, K_RD, 0, 0);  chk("R9 act ignored", errPulse, 1);

    // R9 too few no-operations
    drv(1, K_NOP, 0, 0);
    drv(0, K_REF, 0, 0); drv(1, K_NOP, 0, 0);
    for (int i = 0; i < 3; i++) begin
      drv(1, K_REF, 0, 0); chk("R9 ref in window", errPulse, 1);
    end
    drv(1, K_NOP, 0, 0); st("R9 short nop count", 0, 0, 1);

    // R10 deep power-down
    drv(1, K_ACT, 0, 2); drv(1, K_NOP, 0, 0); drv(1, K_NOP, 0, 0);
    drv(0, K_BST, 0, 0); st("R10 dpd entry", 14, 5, 0);
    drv(0, K_NOP, 0, 0); st("R10 dpd hold", 0, 5, 0);
    drv(1, K_NOP, 0, 0); st("R10 dpd exit", 15, 0, 0);
    drv(1, K_RD, 0, 2);  chk("R10 banks closed", errPulse, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule